// File: doc/BRIEF.md
# Filtered Receive Message FIFO

This block sits between a frame engine and a host. The frame engine opens a frame with a start strobe and then writes message bytes one at a time into a hidden staging buffer. While it does so, a separate acceptance filter reports whether the identifier matches. When the frame ends, the engine gives an ok or an error strobe. Only a frame that ends ok and was reported as matching is copied into a five-entry message queue. A rejected or failed frame is thrown away and leaves no trace.

Each message is fifteen bytes. The host never sees the staging buffer or the later queue entries. It sees only the oldest queued message, the foreground message, which it reads byte by byte through a small read port. A receive-full flag means the foreground holds a valid message. The host releases that message with a clear pulse, and the next waiting message moves up.

A valid frame that arrives while all five entries are taken is dropped, and a sticky overrun flag is raised. A receive interrupt follows the full flag, gated by an enable input.

Top module: `rx_filter_fifo`

## Requirements
- R1: The queue holds at most 5 messages. The host receives them in the same order as their frames completed, and the foreground message is always the oldest one.
- R2: A message is 15 bytes. `fg_byte` is a combinational read of foreground byte `fg_idx` (0 to 14). An `fg_idx` of 15 reads 0.
- R3: A frame is queued when all of the following hold: it ends with `frm_ok` high and `frm_err` low, `filt_hit` was high in at least one cycle from the cycle after `frm_start` up to and including the end cycle, and a frame was open.
- R4: A frame that ends with `frm_err` high, or with `frm_ok` and `frm_err` both high, is discarded and leaves the queue unchanged. A frame that ends without any filter hit is discarded in the same way.
- R5: Staged data works as follows. `frm_start` clears the staging buffer to zero, so bytes never written in the frame are stored as 0. A byte write lands at byte `byte_idx` only in the cycles strictly between the start cycle and the end cycle. Byte writes and `filt_hit` pulses are ignored while no frame is open.
- R6: `rx_full` is high exactly while at least one message is queued. It rises in the cycle after the end strobe of the frame that filled an empty queue.
- R7: A `rxf_clr` pulse while `rx_full` is high removes the foreground message, and the next queued message is readable in the following cycle. `rxf_clr` while `rx_full` is low has no effect.
- R8: A frame that would be queued while 5 messages are held, with no `rxf_clr` in the same cycle, is dropped. `overrun` is then set from the next cycle and stays high until an `ovr_clr` pulse. If a drop and `ovr_clr` happen in the same cycle, the drop wins.
- R9: `rx_irq` is high exactly when `rx_full` and `irq_en` are both high.
- R10: A `frm_start` while a frame is already open abandons that frame and its filter hit, and starts a fresh one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_start | input | 1 | Opens a frame and clears the staging buffer |
| byte_we | input | 1 | Byte write strobe from the frame engine |
| byte_idx | input | 4 | Byte position within the message |
| byte_data | input | 8 | Byte value |
| filt_hit | input | 1 | Acceptance filter reports a match |
| frm_ok | input | 1 | Frame ended without error |
| frm_err | input | 1 | Frame ended with an error |
| fg_idx | input | 4 | Byte select for the foreground read |
| fg_byte | output | 8 | Selected foreground byte |
| rxf_clr | input | 1 | Host releases the foreground message |
| ovr_clr | input | 1 | Host clears the overrun flag |
| irq_en | input | 1 | Receive interrupt enable |
| rx_full | output | 1 | Foreground holds a valid message |
| overrun | output | 1 | A valid frame was lost because the queue was full |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The random part of the bench sends frames with a random length and random skipped byte positions. The filter hit comes early, in the end cycle, or not at all, and the end strobe is ok, error or both. Releases, overrun clears and enable changes fall between the frames, so that correct queue order and contents can be told apart from wrong ones. Directed cases cover what random traffic rarely reaches: filling all five entries and then overrunning, a drop in the same cycle as `ovr_clr`, a restart in mid-frame, writes and filter hits while no frame is open, a release while the queue is empty, and the out-of-range read index.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] rbyte_t;
endpackage

// File: rtl/rxq_stage.sv
module rxq_stage
    import rxq_pkg::*;
#(
    parameter int MSG_BYTES = 15,
    parameter int IDX_W     = $clog2(MSG_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  rbyte_t                    wr_data_i,
    input  logic                      match_i,
    input  logic                      end_ok_i,
    input  logic                      end_err_i,
    output rbyte_t [MSG_BYTES-1:0]    stage_o,
    output logic                      commit_o
);
    typedef struct packed {
        logic                   active;
        logic                   hit;
        rbyte_t [MSG_BYTES-1:0] buf_b;
    } stage_t;

    stage_t st_d, st_q;
    logic   closing;

    always_comb begin
        st_d     = st_q;
        commit_o = 1'b0;
        closing  = st_q.active && (end_ok_i || end_err_i);
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.hit    = 1'b0;
            st_d.buf_b  = '0;
        end else if (closing) begin
            commit_o    = end_ok_i && !end_err_i && (st_q.hit || match_i);
            st_d.active = 1'b0;
            st_d.hit    = 1'b0;
            st_d.buf_b  = '0;
        end else if (st_q.active) begin
            if (match_i) begin
                st_d.hit = 1'b1;
            end
            for (int k = 0; k < MSG_BYTES; k++) begin
                if (wr_en_i && wr_idx_i == IDX_W'(k)) begin
                    st_d.buf_b[k] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.buf_b;

    AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && (end_ok_i || end_err_i) && !start_i) |=> !st_q.active); // R3
    AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start_i) |=> !st_q.hit); // R5
    AST_RESTART_DROPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.active && !st_q.hit)); // R10
endmodule

// File: rtl/rxq_ring.sv
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 5,
    parameter int MSG_BYTES = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_i,
    input  logic                   pop_i,
    input  rbyte_t [MSG_BYTES-1:0] din_i,
    output rbyte_t [MSG_BYTES-1:0] head_o,
    output logic                   avail_o,
    output logic                   drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0]                   rd;
        logic [PTR_W-1:0]                   wr;
        logic [CNT_W-1:0]                   cnt;
        rbyte_t [DEPTH-1:0][MSG_BYTES-1:0]  mem;
    } ring_t;

    ring_t rg_d, rg_q;
    logic  do_pop, do_push;

    always_comb begin
        rg_d    = rg_q;
        do_pop  = pop_i && (rg_q.cnt != '0);
        do_push = push_i && ((rg_q.cnt < CNT_W'(DEPTH)) || do_pop);
        drop_o  = push_i && !do_push;
        if (do_push) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (rg_q.wr == PTR_W'(e)) begin
                    rg_d.mem[e] = din_i;
                end
            end
            rg_d.wr = (rg_q.wr == PTR_W'(DEPTH - 1)) ? '0 : rg_q.wr + 1'b1;
        end
        if (do_pop) begin
            rg_d.rd = (rg_q.rd == PTR_W'(DEPTH - 1)) ? '0 : rg_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            rg_d.cnt = rg_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            rg_d.cnt = rg_q.cnt - 1'b1;
        end
    end

    always_comb begin
        head_o = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (rg_q.rd == PTR_W'(e)) begin
                head_o = rg_q.mem[e];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign avail_o = (rg_q.cnt != '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.cnt <= CNT_W'(DEPTH)); // R1
    AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && avail_o && !push_i) |=> (rg_q.cnt == $past(rg_q.cnt) - 1'b1)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(rg_q.cnt) && $stable(rg_q.rd))); // R4
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (rg_q.cnt == CNT_W'(DEPTH))); // R8
endmodule

// File: rtl/rx_filter_fifo.sv
module rx_filter_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 5,
    parameter int MSG_BYTES = 15,
    parameter int IDX_W     = $clog2(MSG_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              byte_we,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        byte_data,
    input  logic              filt_hit,
    input  logic              frm_ok,
    input  logic              frm_err,
    input  logic [IDX_W-1:0]  fg_idx,
    output logic [7:0]        fg_byte,
    input  logic              rxf_clr,
    input  logic              ovr_clr,
    input  logic              irq_en,
    output logic              rx_full,
    output logic              overrun,
    output logic              rx_irq
);
    typedef struct packed {
        logic ovr;
    } flag_t;

    rbyte_t [MSG_BYTES-1:0] stage_w;
    rbyte_t [MSG_BYTES-1:0] head_w;
    logic                   commit_w;
    logic                   drop_w;
    logic                   avail_w;
    flag_t                  fl_d, fl_q;

    rxq_stage #(.MSG_BYTES(MSG_BYTES), .IDX_W(IDX_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (frm_start),
        .wr_en_i   (byte_we),
        .wr_idx_i  (byte_idx),
        .wr_data_i (byte_data),
        .match_i   (filt_hit),
        .end_ok_i  (frm_ok),
        .end_err_i (frm_err),
        .stage_o   (stage_w),
        .commit_o  (commit_w)
    );

    rxq_ring #(.DEPTH(DEPTH), .MSG_BYTES(MSG_BYTES)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (commit_w),
        .pop_i   (rxf_clr),
        .din_i   (stage_w),
        .head_o  (head_w),
        .avail_o (avail_w),
        .drop_o  (drop_w)
    );

    always_comb begin
        fl_d     = fl_q;
        fl_d.ovr = (fl_q.ovr && !ovr_clr) || drop_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_comb begin
        fg_byte = '0;
        for (int k = 0; k < MSG_BYTES; k++) begin
            if (fg_idx == IDX_W'(k)) begin
                fg_byte = head_w[k];
            end
        end
    end

    assign rx_full = avail_w;
    assign overrun = fl_q.ovr;
    assign rx_irq  = avail_w && irq_en;

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        drop_w |=> overrun); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R8
    AST_FULL_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_w && !rx_full) |=> rx_full); // R6
    AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full); // R9
endmodule

// File: tb/tb_rx_filter_fifo.sv
`timescale 1ns/100ps
module tb_rx_filter_fifo;
    localparam int CLK_P = 10;
    localparam int NQ    = 5;
    localparam int NB    = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 0, byte_we = 0, filt_hit = 0, frm_ok = 0, frm_err = 0;
    logic [3:0] byte_idx = 0, fg_idx = 0;
    logic [7:0] byte_data = 0;
    logic rxf_clr = 0, ovr_clr = 0, irq_en = 0;
    logic [7:0] fg_byte;
    logic rx_full, overrun, rx_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] mq [NQ][NB];
    int mcnt = 0;
    bit movr = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    rx_filter_fifo dut (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_we(byte_we),
        .byte_idx(byte_idx), .byte_data(byte_data), .filt_hit(filt_hit),
        .frm_ok(frm_ok), .frm_err(frm_err), .fg_idx(fg_idx), .fg_byte(fg_byte),
        .rxf_clr(rxf_clr), .ovr_clr(ovr_clr), .irq_en(irq_en),
        .rx_full(rx_full), .overrun(overrun), .rx_irq(rx_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [7:0] f [NB]);
        if (mcnt < NQ) begin
            for (int k = 0; k < NB; k++) mq[mcnt][k] = f[k];
            mcnt++;
        end else begin
            movr = 1;
        end
    endtask

    task automatic model_pop();
        if (mcnt > 0) begin
            for (int e = 0; e < NQ - 1; e++)
                for (int k = 0; k < NB; k++) mq[e][k] = mq[e+1][k];
            mcnt--;
        end
    endtask

    // compare flags and, when a message waits, all foreground bytes
    task automatic check_all(input string req);
        chk({req, " R6 rx_full"}, int'(rx_full), int'(mcnt > 0));
        chk({req, " R8 overrun"}, int'(overrun), int'(movr));
        chk({req, " R9 rx_irq"}, int'(rx_irq), int'((mcnt > 0) && irq_en));
        if (mcnt > 0) begin
            int bad = -1;
            int av = 0, ev = 0;
            for (int k = 0; k < NB; k++) begin
                fg_idx = 4'(k);
                #0.1;
                if (bad < 0 && fg_byte != mq[0][k]) begin
                    bad = k; av = int'(fg_byte); ev = int'(mq[0][k]);
                end
            end
            checks++;
            if (bad >= 0) begin
                errors++;
                $display("FAIL %s R1 R2 foreground byte %0d actual %0d expected %0d",
                         req, bad, av, ev);
            end
        end
    endtask

    // hit_mid: filter hit during bytes; hit_end: in end cycle
    task automatic send_frame(input int n, input bit hit_mid, input bit hit_end,
                              input bit ok, input bit err);
        logic [7:0] f [NB];
        int hpos;
        for (int k = 0; k < NB; k++) f[k] = 8'h00;
        hpos = (n > 0) ? int'($urandom_range(n - 1)) : 0;
        frm_start = 1; tick(); frm_start = 0;
        if (hit_mid && n == 0) begin
            filt_hit = 1; tick(); filt_hit = 0;
        end
        for (int i = 0; i < n; i++) begin
            byte_idx = 4'(i);
            byte_data = 8'($urandom);
            byte_we = ($urandom_range(3) != 0);
            if (byte_we) f[i] = byte_data;
            filt_hit = hit_mid && (i == hpos);
            tick();
            byte_we = 0; filt_hit = 0;
        end
        frm_ok = ok; frm_err = err; filt_hit = hit_end;
        tick();
        frm_ok = 0; frm_err = 0; filt_hit = 0;
        if (ok && !err && (hit_mid || hit_end)) model_push(f);
    endtask

    task automatic release_fg();
        rxf_clr = 1; tick(); rxf_clr = 0;
        model_pop();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        #(CLK_P * 3);
        rst_n = 1;
        tick();
        // reset state
        check_all("reset");
        for (int k = 0; k < NB; k++) begin
            fg_idx = 4'(k); #0.1;
            chk("reset R2 foreground zero", int'(fg_byte), 0);
        end

        // R3 basic accept, interrupt disabled then enabled
        send_frame(15, 1, 0, 1, 0);
        check_all("R3 accept");
        irq_en = 1; #0.1;
        check_all("R9 irq enabled");
        fg_idx = 4'd15; #0.1;
        chk("R2 index 15 reads zero", int'(fg_byte), 0);
        release_fg();
        check_all("R7 release to empty");

        // R7 release while empty has no effect
        release_fg();
        check_all("R7 release empty");

        // R4 error, both strobes, no hit
        send_frame(8, 1, 0, 0, 1);
        check_all("R4 error end");
        send_frame(8, 1, 1, 1, 1);
        check_all("R4 ok and err");
        send_frame(8, 0, 0, 1, 0);
        check_all("R4 no hit");

        // R3 hit only in end cycle
        send_frame(4, 0, 1, 1, 0);
        check_all("R3 hit in end cycle");
        release_fg();

        // R5 writes and hits outside a frame are ignored
        byte_we = 1; byte_idx = 2; byte_data = 8'hA5; filt_hit = 1;
        tick();
        byte_we = 0; filt_hit = 0;
        send_frame(0, 0, 0, 1, 0);
        check_all("R5 idle hit ignored");
        send_frame(0, 0, 1, 1, 0);
        check_all("R5 idle write ignored zero message");
        release_fg();

        // R10 restart mid-frame discards earlier hit and bytes
        frm_start = 1; tick(); frm_start = 0;
        byte_we = 1; byte_idx = 0; byte_data = 8'h77; filt_hit = 1; tick();
        byte_we = 0; filt_hit = 0;
        send_frame(3, 0, 0, 1, 0);
        check_all("R10 restart drops hit");
        send_frame(3, 1, 0, 1, 0);
        check_all("R10 fresh frame accepted");
        release_fg();

        // R1 R8 fill and overrun
        for (int i = 0; i < NQ; i++) send_frame(6 + i, 1, 0, 1, 0);
        check_all("R1 five queued");
        send_frame(5, 1, 0, 1, 0);
        check_all("R8 overrun drop");
        ovr_clr = 1; tick(); ovr_clr = 0; movr = 0;
        check_all("R8 overrun clear");
        // drop and clear in same cycle: set wins
        frm_start = 1; tick(); frm_start = 0;
        filt_hit = 1; tick(); filt_hit = 0;
        frm_ok = 1; ovr_clr = 1; tick(); frm_ok = 0; ovr_clr = 0; movr = 1;
        check_all("R8 drop beats clear");
        for (int i = 0; i < NQ; i++) begin
            release_fg();
            check_all("R1 R7 drain order");
        end
        ovr_clr = 1; tick(); ovr_clr = 0; movr = 0;

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(9));
            if (op < 5) begin
                int r = int'($urandom_range(3));
                send_frame(int'($urandom_range(NB)), r == 0 || r == 1, r == 2,
                           $urandom_range(4) != 0, $urandom_range(5) == 0);
            end else if (op < 8) begin
                release_fg();
            end else if (op == 8) begin
                ovr_clr = 1; tick(); ovr_clr = 0; movr = 0;
            end else begin
                irq_en = ~irq_en; tick();
            end
            check_all("R1 R3 R4 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule